// File: doc/BRIEF.md
# Port-Mapped RAM Disk Controller

This block places a RAM disk behind the I/O port space of an 8-bit processor, so the disk uses no memory address range. Software selects a sector by writing a track number and a sector number to two address ports. It then moves the sector's bytes one at a time through a single data port. The block joins the track latch, the sector latch and a byte offset into one flat RAM address. It returns the addressed byte on a read of the data port, and it issues a one-cycle write strobe on a write to the data port.

The byte offset inside a 128-byte sector comes from one of two sources, chosen by a parameter. In counter mode, an internal 7-bit counter is cleared whenever either address latch is written and advances after every data-port access, so a sector streams through repeated accesses to the same port. In upper-line mode, CPU address bits 8 to 14 carry the offset directly. The processor's own block-transfer count register can then address the byte, and the block keeps no counter. In both modes, loading the track and sector is the only setup needed before a transfer.

Top module: `ramdisk_port_ctrl`

## Requirements
- R1: After reset, the track latch, the sector latch and the byte counter are zero, so `ram_addr` is 0, and `ram_we` is low.
- R2: A write to the track port (offset 0 from `BASE_PORT`) loads `io_wdata[TRACK_W-1:0]` into the track latch and clears the byte counter to 0.
- R3: A write to the sector port (offset 1) loads `io_wdata[SECTOR_W-1:0]` into the sector latch and clears the byte counter to 0.
- R4: `ram_addr` is `{track, sector, byte}`, with the byte offset in bits 6..0. The latches keep their value on every cycle in which they are not written.
- R5: A write to the data port (offset 2) raises `ram_we` in the same cycle, with `ram_wdata` equal to `io_wdata`, at the current address. In counter mode the counter then advances by one.
- R6: A read of the data port returns the RAM byte at the current address, taken before the counter advances. The counter then advances by one.
- R7: The byte counter wraps from 127 to 0 and leaves the track and sector latches unchanged.
- R8: A read of the track or sector port returns that latch, zero-extended to 8 bits, and does not move the byte counter.
- R9: In upper-line mode, the byte offset in `ram_addr[6:0]` equals `io_upper` (CPU address bits 8 to 14) and no counter state is kept.
- R10: An access to any other port changes no latch and no counter, does not write RAM, and reads back as 8'hFF.
- R11: `ram_we` is high only during a data-port write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O access strobe |
| io_wr | input | 1 | 1 = write (OUT), 0 = read (IN) |
| io_port | input | 8 | Low I/O address (port number) |
| io_upper | input | BYTE_W | CPU address bits 8 and up, used as the byte offset in upper-line mode |
| io_wdata | input | 8 | Write data from the CPU |
| io_rdata | output | 8 | Read data to the CPU (combinational) |
| ram_addr | output | TRACK_W+SECTOR_W+BYTE_W | Flat RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, asynchronous to `ram_addr` |

## Verification
The assertions take for granted that `io_req` is a single-cycle strobe that fully describes an access within its cycle. They also assume the RAM returns `ram_rdata` combinationally for the address shown, and that `io_upper` only carries meaning while a request is active. The stimulus keeps to these assumptions: it drives each access for exactly one clock, away from the edge, and it models the RAM as an array read asynchronously. It mixes random port choices, data values and upper-line values, weighted towards the data port, with directed runs past the 127-to-0 wrap and accesses to unmapped ports.

// File: rtl/rdk_pkg.sv
package rdk_pkg;
   typedef enum logic [1:0] {
      RDK_SEL_NONE   = 2'd0,
      RDK_SEL_TRACK  = 2'd1,
      RDK_SEL_SECTOR = 2'd2,
      RDK_SEL_DATA   = 2'd3
   } rdk_sel_e;

   localparam int unsigned RDK_OFS_TRACK  = 0;
   localparam int unsigned RDK_OFS_SECTOR = 1;
   localparam int unsigned RDK_OFS_DATA   = 2;
endpackage

// File: rtl/rdk_port_decode.sv
module rdk_port_decode
   import rdk_pkg::*;
#(
   parameter logic [7:0] BASE_PORT = 8'h40
) (
   input  logic [7:0] port,
   output rdk_sel_e   sel
);
   localparam logic [7:0] P_TRACK  = BASE_PORT + 8'(RDK_OFS_TRACK);
   localparam logic [7:0] P_SECTOR = BASE_PORT + 8'(RDK_OFS_SECTOR);
   localparam logic [7:0] P_DATA   = BASE_PORT + 8'(RDK_OFS_DATA);

   if (BASE_PORT > 8'hFD) begin : g_bad_base
      $error("rdk_port_decode: BASE_PORT leaves no room for three ports");
   end

   always_comb begin
      unique case (port)
         P_TRACK:  sel = RDK_SEL_TRACK;
         P_SECTOR: sel = RDK_SEL_SECTOR;
         P_DATA:   sel = RDK_SEL_DATA;
         default:  sel = RDK_SEL_NONE;
      endcase
   end
endmodule

// File: rtl/rdk_addr_latch.sv
module rdk_addr_latch #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   if (W < 1 || W > 8) begin : g_bad_w
      $error("rdk_addr_latch: W must be 1..8");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/rdk_byte_offset.sv
module rdk_byte_offset #(
   parameter int unsigned BYTE_W    = 7,
   parameter bit          USE_UPPER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [BYTE_W-1:0] upper,
   output logic [BYTE_W-1:0] offset
);
   if (BYTE_W < 1 || BYTE_W > 8) begin : g_bad_bw
      $error("rdk_byte_offset: BYTE_W must be 1..8");
   end

   if (USE_UPPER) begin : g_upper
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, clear, step};
      assign offset    = upper;
   end else begin : g_count
      logic [BYTE_W-1:0] cnt_q;
      logic              unused_ok;
      assign unused_ok = ^upper;

      always_ff @(posedge clk) begin
         if (!rst_n)     cnt_q <= '0;
         else if (clear) cnt_q <= '0;
         else if (step)  cnt_q <= cnt_q + 1'b1;
      end
      assign offset = cnt_q;
   end
endmodule

// File: rtl/ramdisk_port_ctrl.sv
module ramdisk_port_ctrl
   import rdk_pkg::*;
#(
   parameter int unsigned TRACK_W   = 8,
   parameter int unsigned SECTOR_W  = 8,
   parameter int unsigned BYTE_W    = 7,
   parameter logic [7:0]  BASE_PORT = 8'h40,
   parameter bit          USE_UPPER = 1'b0,
   localparam int unsigned ADDR_W   = TRACK_W + SECTOR_W + BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              io_wr,
   input  logic [7:0]        io_port,
   input  logic [BYTE_W-1:0] io_upper,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_we,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata
);
   localparam logic [7:0] P_TRACK  = BASE_PORT + 8'(RDK_OFS_TRACK);
   localparam logic [7:0] P_SECTOR = BASE_PORT + 8'(RDK_OFS_SECTOR);
   localparam logic [7:0] P_DATA   = BASE_PORT + 8'(RDK_OFS_DATA);

   if (TRACK_W < 1 || TRACK_W > 8 || SECTOR_W < 1 || SECTOR_W > 8) begin : g_bad_lat
      $error("ramdisk_port_ctrl: latch widths must be 1..8");
   end

   rdk_sel_e          sel;
   logic [TRACK_W-1:0]  trk;
   logic [SECTOR_W-1:0] sec;
   logic [BYTE_W-1:0]   ofs;
   logic ld_trk, ld_sec, data_acc;

   rdk_port_decode #(.BASE_PORT(BASE_PORT)) u_dec (
      .port(io_port), .sel(sel)
   );

   assign ld_trk   = io_req && io_wr && (sel == RDK_SEL_TRACK);
   assign ld_sec   = io_req && io_wr && (sel == RDK_SEL_SECTOR);
   assign data_acc = io_req && (sel == RDK_SEL_DATA);

   rdk_addr_latch #(.W(TRACK_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .load(ld_trk),
      .din(io_wdata[TRACK_W-1:0]), .q(trk)
   );

   rdk_addr_latch #(.W(SECTOR_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .load(ld_sec),
      .din(io_wdata[SECTOR_W-1:0]), .q(sec)
   );

   rdk_byte_offset #(.BYTE_W(BYTE_W), .USE_UPPER(USE_UPPER)) u_ofs (
      .clk(clk), .rst_n(rst_n), .clear(ld_trk || ld_sec),
      .step(data_acc), .upper(io_upper), .offset(ofs)
   );

   assign ram_addr  = {trk, sec, ofs};
   assign ram_we    = data_acc && io_wr;
   assign ram_wdata = io_wdata;

   always_comb begin
      unique case (sel)
         RDK_SEL_TRACK:  io_rdata = 8'(trk);
         RDK_SEL_SECTOR: io_rdata = 8'(sec);
         RDK_SEL_DATA:   io_rdata = ram_rdata;
         default:        io_rdata = 8'hFF;
      endcase
   end

   // ---------------- assertions ----------------
   assert_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (io_req && io_wr && io_port == P_DATA));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_req && io_wr && (io_port == P_TRACK || io_port == P_SECTOR))
      |=> $stable(ram_addr[ADDR_W-1:BYTE_W]));

   assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_wr && io_port != P_TRACK && io_port != P_SECTOR
       && io_port != P_DATA) |-> (io_rdata == 8'hFF));

   if (USE_UPPER) begin : g_chk_upper
      assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
         io_req |-> (ram_addr[BYTE_W-1:0] == io_upper));
   end else begin : g_chk_count
      assert_clear_trk_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (io_req && io_wr && io_port == P_TRACK) |=> (ram_addr[BYTE_W-1:0] == '0));

      assert_clear_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (io_req && io_wr && io_port == P_SECTOR) |=> (ram_addr[BYTE_W-1:0] == '0));

      assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (io_req && io_port == P_DATA)
         |=> (ram_addr[BYTE_W-1:0] == BYTE_W'($past(ram_addr[BYTE_W-1:0]) + 1'b1)));

      assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (io_req && io_port == P_DATA && (&ram_addr[BYTE_W-1:0]))
         |=> (ram_addr == {$past(ram_addr[ADDR_W-1:BYTE_W]), BYTE_W'(0)}));

      assert_rdlatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (io_req && !io_wr && (io_port == P_TRACK || io_port == P_SECTOR))
         |=> $stable(ram_addr));
   end
endmodule

// File: tb/ramdisk_port_ctrl_test.sv
`timescale 1ns/1ps
module ramdisk_port_ctrl_test;
   localparam int TW = 3;
   localparam int SW = 4;
   localparam int BW = 7;
   localparam int AW = TW + SW + BW;
   localparam int DEPTH = 1 << AW;
   localparam logic [7:0] BASE = 8'h40;
   localparam logic [7:0] PT = BASE;
   localparam logic [7:0] PS = BASE + 8'd1;
   localparam logic [7:0] PD = BASE + 8'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic io_req = 1'b0, io_wr = 1'b0;
   logic [7:0] io_port = 8'h00, io_wdata = 8'h00;
   logic [BW-1:0] io_upper = '0;
   logic [7:0] rdata_a, rdata_b, wdata_a, wdata_b, rram_a, rram_b;
   logic [AW-1:0] addr_a, addr_b;
   logic we_a, we_b;

   logic [7:0] mem_a [0:DEPTH-1];
   logic [7:0] mem_b [0:DEPTH-1];
   logic [7:0] ref_a [0:DEPTH-1];
   logic [7:0] ref_b [0:DEPTH-1];

   logic [TW-1:0] m_trk = '0;
   logic [SW-1:0] m_sec = '0;
   logic [BW-1:0] m_cnt = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ramdisk_port_ctrl #(.TRACK_W(TW), .SECTOR_W(SW), .BYTE_W(BW),
                       .BASE_PORT(BASE), .USE_UPPER(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
      .io_port(io_port), .io_upper(io_upper), .io_wdata(io_wdata),
      .io_rdata(rdata_a), .ram_addr(addr_a), .ram_we(we_a),
      .ram_wdata(wdata_a), .ram_rdata(rram_a)
   );

   ramdisk_port_ctrl #(.TRACK_W(TW), .SECTOR_W(SW), .BYTE_W(BW),
                       .BASE_PORT(BASE), .USE_UPPER(1'b1)) uut_hw (
      .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
      .io_port(io_port), .io_upper(io_upper), .io_wdata(io_wdata),
      .io_rdata(rdata_b), .ram_addr(addr_b), .ram_we(we_b),
      .ram_wdata(wdata_b), .ram_rdata(rram_b)
   );

   assign rram_a = mem_a[addr_a];
   assign rram_b = mem_b[addr_b];

   always @(posedge clk) begin
      if (we_a) mem_a[addr_a] <= wdata_a;
      if (we_b) mem_b[addr_b] <= wdata_b;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr_a();
      return {m_trk, m_sec, m_cnt};
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] port, input logic [7:0] mem_val);
      if (port == PT) return 8'(m_trk);
      if (port == PS) return 8'(m_sec);
      if (port == PD) return mem_val;
      return 8'hFF;
   endfunction

   task automatic do_op(input logic wr, input logic [7:0] port,
                        input logic [7:0] wd, input logic [BW-1:0] up);
      logic [AW-1:0] ea, eb;
      @(negedge clk);
      io_req = 1'b1; io_wr = wr; io_port = port; io_wdata = wd; io_upper = up;
      #1;
      ea = exp_addr_a();
      eb = {m_trk, m_sec, up};
      chk("R4 counter addr", 32'(addr_a), 32'(ea));
      chk("R9 upper addr", 32'(addr_b), 32'(eb));
      chk("R11 we", 32'(we_a), 32'(wr && port == PD));
      chk("R11 we upper", 32'(we_b), 32'(wr && port == PD));
      if (wr && port == PD) begin
         chk("R5 wdata", 32'(wdata_a), 32'(wd));
      end
      if (!wr) begin
         chk(port == PD ? "R6 read" : (port == PT || port == PS) ? "R8 readback" : "R10 unmapped",
             32'(rdata_a), 32'(exp_read(port, ref_a[ea])));
         chk("R9 read", 32'(rdata_b), 32'(exp_read(port, ref_b[eb])));
      end
      @(posedge clk);
      #1;
      io_req = 1'b0;
      if (wr && port == PT) begin m_trk = wd[TW-1:0]; m_cnt = '0; end
      else if (wr && port == PS) begin m_sec = wd[SW-1:0]; m_cnt = '0; end
      else if (port == PD) begin
         if (wr) begin ref_a[ea] = wd; ref_b[eb] = wd; end
         m_cnt = m_cnt + 1'b1;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] p;
      int r;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) begin
         mem_a[i] = 8'(i * 7 + 3); ref_a[i] = 8'(i * 7 + 3);
         mem_b[i] = 8'(i * 5 + 1); ref_b[i] = 8'(i * 5 + 1);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 addr", 32'(addr_a), 32'd0);
      chk("R1 we", 32'(we_a), 32'd0);
      chk("R1 upper-mode latches", 32'(addr_b[AW-1:BW]), 32'd0);

      // R2/R3: load latches, counter cleared
      do_op(1'b1, PT, 8'hF5, 7'd0);
      do_op(1'b1, PS, 8'h39, 7'd0);
      do_op(1'b0, PT, 8'h00, 7'd0); // R8 readback track
      do_op(1'b0, PS, 8'h00, 7'd0); // R8 readback sector
      // R7: stream past the wrap
      for (int k = 0; k < 130; k++) do_op(1'b1, PD, 8'(k ^ 8'hA5), 7'(k));
      #1 chk("R7 wrap offset", 32'(addr_a[BW-1:0]), 32'd2);
      chk("R7 sector kept", 32'(addr_a[BW+SW-1:BW]), 32'h9);
      chk("R7 track kept", 32'(addr_a[AW-1:BW+SW]), 32'h5);
      // R6: read the sector back after a clear by sector write
      do_op(1'b1, PS, 8'h09, 7'd0);
      chk("R3 clear", 32'(addr_a[BW-1:0]), 32'd0);
      for (int k = 0; k < 128; k++) do_op(1'b0, PD, 8'h00, 7'(127 - k));
      // R10: unmapped ports
      do_op(1'b1, 8'h43, 8'h00, 7'd1);
      do_op(1'b1, 8'h3F, 8'h77, 7'd2);
      do_op(1'b0, 8'hFF, 8'h00, 7'd3);
      chk("R10 latches unchanged", 32'(addr_a[AW-1:BW]), 32'(exp_addr_a() >> BW));

      // random mix
      for (int n = 0; n < 3000; n++) begin
         r = int'($urandom_range(0, 9));
         case (r)
            0: p = PT;
            1: p = PS;
            2: p = 8'($urandom_range(0, 255));
            default: p = PD;
         endcase
         do_op(1'($urandom_range(0, 1)), p, 8'($urandom_range(0, 255)),
               7'($urandom_range(0, 127)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule